// File: doc/BRIEF.md
# Bridge Window BAR Decoder

This block works out where each of a device's address regions actually lands once the device's own decode rules and an upstream bridge's forwarding windows have both been applied. For every region it takes the raw base-address register value, the region's size (as a power of two), its kind and its prefetch attribute. It also takes the device's I/O-space and memory-space enables and the bridge's packed window registers. From these it produces an effective base, an effective size and a mapped flag.

The block first aligns each region and applies the validity rules for its kind: a zero address, an end that wraps, an I/O end at or above 64 KiB, a 32-bit memory end reaching the all-ones 32-bit address, and a ROM region whose enable bit is clear are all rejected. It then decodes the bridge's I/O, memory and prefetchable windows, picks the window matching the region, and intersects the two ranges. When no bridge sits above the device, the clipping step is bypassed.

Results are held in registers and reloaded only on a one-cycle remap strobe, so the consumer sees a consistent snapshot of all regions. A completion pulse marks the cycle in which a new snapshot is visible. All pins are plain control and status: no data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `bridge_bar_decoder`

## Requirements
- R1: Outputs change only on the clock edge at which `remap_i` is 1. At that edge they load the result computed from the inputs present at that edge, and `remap_done` is 1 for exactly the following cycle. With `remap_i` at 0 every output except `remap_done` holds its value, and `remap_done` is 0.
- R2: While `rst_n` is 0, and after reset until the first strobe, every `map_valid`, `map_base`, `map_size` and `remap_done` bit is 0.
- R3: A region of kind 0 (I/O) uses bits 31:0 of its register value. It is mapped only when `io_space_en` is 1, its aligned address is non-zero, its end (address + size − 1) is above its address, and its end is below 0x10000.
- R4: A region of kind 1 (32-bit memory), 2 (64-bit memory) or 3 (ROM) is mapped only when `mem_space_en` is 1, its aligned address is non-zero and its end does not wrap. The end must also not be all ones, and for kinds 1 and 3 it must be below 0xFFFFFFFF. Kinds 1 and 3 use bits 31:0 of the register value only; kind 2 uses all 64 bits.
- R5: A kind 3 (ROM) region is unmapped when bit 0 of its register value is 0.
- R6: The region address is its register value with the low `size_log2` bits cleared, and its unclipped size is 2^`size_log2`.
- R7: The I/O window base is `(win_io_base_lo & 0xF0) << 8`. When bit 0 of `win_io_base_lo` is 1, `win_io_base_hi` is added as bits 31:16; when that bit is 0, `win_io_base_hi` is ignored. The limit is decoded the same way from `win_io_limit_lo` and `win_io_limit_hi`, then ORed with 0xFFF.
- R8: The memory window base is `(win_mem_base & 0xFFF0) << 16`. The limit is `((win_mem_limit & 0xFFF0) << 16) | 0xFFFFF`.
- R9: The prefetchable window is decoded like the memory window, with `win_pf_base_hi` and `win_pf_limit_hi` supplying bits 63:32. It applies to memory-kind regions whose `reg_prefetch` bit is 1; other memory regions use the memory window, and I/O regions use the I/O window.
- R10: With `bridge_present` at 1, a region that passes its own rules is mapped from max(address, window base) to min(end, window limit), with size end − start + 1. If the start exceeds the end, the region is unmapped.
- R11: With `bridge_present` at 0, the window registers have no effect and a region that passes its own rules reports its aligned address and full size.
- R12: A `size_log2` of 0 marks a region as not implemented, and that region is unmapped. Every unmapped region reports a base and a size of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| remap_i | input | 1 | Strobe: load a new snapshot at this edge |
| io_space_en | input | 1 | Device I/O space decode enable |
| mem_space_en | input | 1 | Device memory space decode enable |
| bridge_present | input | 1 | An upstream bridge clips the regions |
| win_io_base_lo | input | 8 | Bridge I/O base byte (bits 7:4 address, bit 0 selects 32-bit I/O) |
| win_io_limit_lo | input | 8 | Bridge I/O limit byte, same encoding |
| win_io_base_hi | input | 16 | Bridge I/O base bits 31:16 |
| win_io_limit_hi | input | 16 | Bridge I/O limit bits 31:16 |
| win_mem_base | input | 16 | Bridge memory base word (bits 15:4 address) |
| win_mem_limit | input | 16 | Bridge memory limit word |
| win_pf_base_lo | input | 16 | Bridge prefetchable base word |
| win_pf_limit_lo | input | 16 | Bridge prefetchable limit word |
| win_pf_base_hi | input | 32 | Bridge prefetchable base bits 63:32 |
| win_pf_limit_hi | input | 32 | Bridge prefetchable limit bits 63:32 |
| reg_kind | input | NUM_REG x 2 | Region kind: 0 I/O, 1 mem32, 2 mem64, 3 ROM |
| reg_prefetch | input | NUM_REG | Region is prefetchable |
| reg_size_log2 | input | NUM_REG x 6 | log2 of region size, 0 = not implemented |
| reg_bar | input | NUM_REG x 64 | Raw base-address register value |
| map_valid | output | NUM_REG | Region is mapped |
| map_base | output | NUM_REG x 64 | Effective base address |
| map_size | output | NUM_REG x 64 | Effective size in bytes |
| remap_done | output | 1 | New snapshot visible this cycle |

## Verification
On every cycle the assertions check several properties. Outputs hold between strobes, and the completion pulse follows each strobe exactly. Unmapped regions carry a zero base and size, while mapped regions carry a non-zero base and size. A strobe taken with the relevant space enable clear never yields a mapped region. The exact arithmetic can only be shown by the bench's scenarios against hand-computed values. This covers alignment, the 64 KiB and 4 GiB end limits, the all-ones 64-bit end, window decoding from the packed encodings (including the 32-bit I/O selector), the choice of prefetchable versus plain window, and partial or empty intersections.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int AW  = 64;
  localparam int LGW = $clog2(AW);

  typedef logic [AW-1:0] addr_t;

  typedef enum logic [1:0] {
    KIND_IO    = 2'd0,
    KIND_MEM32 = 2'd1,
    KIND_MEM64 = 2'd2,
    KIND_ROM   = 2'd3
  } bar_kind_e;

  typedef struct packed {
    addr_t base;
    addr_t limit;
  } win_t;

  typedef struct packed {
    logic  ok;
    addr_t first;
    addr_t last;
  } rng_t;
endpackage

// File: rtl/bwd_window_decode.sv
module bwd_window_decode
  import bwd_pkg::*;
(
  input  logic [7:0]  io_base_lo,
  input  logic [7:0]  io_limit_lo,
  input  logic [15:0] io_base_hi,
  input  logic [15:0] io_limit_hi,
  input  logic [15:0] mem_base,
  input  logic [15:0] mem_limit,
  input  logic [15:0] pf_base_lo,
  input  logic [15:0] pf_limit_lo,
  input  logic [31:0] pf_base_hi,
  input  logic [31:0] pf_limit_hi,
  output win_t        io_win,
  output win_t        mem_win,
  output win_t        pf_win
);
  localparam logic [7:0]  IO_RANGE_M  = 8'hF0;
  localparam logic [15:0] MEM_RANGE_M = 16'hFFF0;
  localparam addr_t       IO_GRAIN    = addr_t'(12'hFFF);
  localparam addr_t       MEM_GRAIN   = addr_t'(20'hFFFFF);

  // packed I/O byte: address nibble in 7:4, bit 0 enables the upper half
  function automatic addr_t io_addr(input logic [7:0] lo, input logic [15:0] hi);
    addr_t a;
    a = addr_t'(lo & IO_RANGE_M) << 8;
    if (lo[0]) a = a | (addr_t'(hi) << 16);
    return a;
  endfunction

  function automatic addr_t mem_addr(input logic [15:0] w, input logic [31:0] hi);
    return (addr_t'(w & MEM_RANGE_M) << 16) | (addr_t'(hi) << 32);
  endfunction

  always_comb begin
    io_win.base   = io_addr(io_base_lo, io_base_hi);
    io_win.limit  = io_addr(io_limit_lo, io_limit_hi) | IO_GRAIN;
    mem_win.base  = mem_addr(mem_base, 32'h0);
    mem_win.limit = mem_addr(mem_limit, 32'h0) | MEM_GRAIN;
    pf_win.base   = mem_addr(pf_base_lo, pf_base_hi);
    pf_win.limit  = mem_addr(pf_limit_lo, pf_limit_hi) | MEM_GRAIN;
  end
endmodule

// File: rtl/bwd_bar_check.sv
module bwd_bar_check
  import bwd_pkg::*;
(
  input  logic [1:0]     kind,
  input  logic [LGW-1:0] size_log2,
  input  addr_t          bar,
  input  logic           io_en,
  input  logic           mem_en,
  output rng_t           rng
);
  localparam addr_t IO_END_CAP  = addr_t'(32'h0001_0000);
  localparam addr_t M32_END_CAP = addr_t'(32'hFFFF_FFFF);

  addr_t mask, raw, aligned, last;
  logic  present, no_wrap, is_io, is_wide, rom_gate;

  always_comb begin
    present  = size_log2 != '0;
    mask     = (addr_t'(1) << size_log2) - addr_t'(1);
    is_io    = kind == KIND_IO;
    is_wide  = kind == KIND_MEM64;
    rom_gate = (kind != KIND_ROM) || bar[0];
    raw      = is_wide ? bar : addr_t'(bar[31:0]);
    aligned  = raw & ~mask;
    last     = aligned + mask;
    no_wrap  = last > aligned;
    rng.first = aligned;
    rng.last  = last;
    if (is_io)
      rng.ok = present && io_en && no_wrap && (aligned != '0) && (last < IO_END_CAP);
    else
      rng.ok = present && mem_en && rom_gate && no_wrap && (aligned != '0) &&
               (last != '1) && (is_wide || (last < M32_END_CAP));
  end
endmodule

// File: rtl/bwd_clip.sv
module bwd_clip
  import bwd_pkg::*;
(
  input  rng_t  rng,
  input  win_t  win,
  input  logic  clip_en,
  output logic  ok,
  output addr_t base,
  output addr_t size
);
  addr_t first, last;

  always_comb begin
    first = rng.first;
    last  = rng.last;
    if (clip_en) begin
      if (win.base > first) first = win.base;
      if (win.limit < last) last = win.limit;
    end
    ok   = rng.ok && (first <= last);
    base = ok ? first : '0;
    size = ok ? (last - first + addr_t'(1)) : '0;
  end
endmodule

// File: rtl/bridge_bar_decoder.sv
module bridge_bar_decoder
  import bwd_pkg::*;
#(
  parameter int NUM_REG = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          remap_i,
  input  logic                          io_space_en,
  input  logic                          mem_space_en,
  input  logic                          bridge_present,
  input  logic [7:0]                    win_io_base_lo,
  input  logic [7:0]                    win_io_limit_lo,
  input  logic [15:0]                   win_io_base_hi,
  input  logic [15:0]                   win_io_limit_hi,
  input  logic [15:0]                   win_mem_base,
  input  logic [15:0]                   win_mem_limit,
  input  logic [15:0]                   win_pf_base_lo,
  input  logic [15:0]                   win_pf_limit_lo,
  input  logic [31:0]                   win_pf_base_hi,
  input  logic [31:0]                   win_pf_limit_hi,
  input  logic [NUM_REG-1:0][1:0]       reg_kind,
  input  logic [NUM_REG-1:0]            reg_prefetch,
  input  logic [NUM_REG-1:0][LGW-1:0]   reg_size_log2,
  input  logic [NUM_REG-1:0][AW-1:0]    reg_bar,
  output logic [NUM_REG-1:0]            map_valid,
  output logic [NUM_REG-1:0][AW-1:0]    map_base,
  output logic [NUM_REG-1:0][AW-1:0]    map_size,
  output logic                          remap_done
);
  win_t io_win, mem_win, pf_win;

  bwd_window_decode u_win (
    .io_base_lo  (win_io_base_lo),
    .io_limit_lo (win_io_limit_lo),
    .io_base_hi  (win_io_base_hi),
    .io_limit_hi (win_io_limit_hi),
    .mem_base    (win_mem_base),
    .mem_limit   (win_mem_limit),
    .pf_base_lo  (win_pf_base_lo),
    .pf_limit_lo (win_pf_limit_lo),
    .pf_base_hi  (win_pf_base_hi),
    .pf_limit_hi (win_pf_limit_hi),
    .io_win      (io_win),
    .mem_win     (mem_win),
    .pf_win      (pf_win)
  );

  logic [NUM_REG-1:0]         nxt_ok;
  logic [NUM_REG-1:0][AW-1:0] nxt_base;
  logic [NUM_REG-1:0][AW-1:0] nxt_size;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    rng_t rng;
    win_t sel;

    bwd_bar_check u_chk (
      .kind      (reg_kind[g]),
      .size_log2 (reg_size_log2[g]),
      .bar       (reg_bar[g]),
      .io_en     (io_space_en),
      .mem_en    (mem_space_en),
      .rng       (rng)
    );

    always_comb begin
      if (reg_kind[g] == KIND_IO) sel = io_win;
      else if (reg_prefetch[g])   sel = pf_win;
      else                        sel = mem_win;
    end

    bwd_clip u_clip (
      .rng     (rng),
      .win     (sel),
      .clip_en (bridge_present),
      .ok      (nxt_ok[g]),
      .base    (nxt_base[g]),
      .size    (nxt_size[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_valid  <= '0;
      map_base   <= '0;
      map_size   <= '0;
      remap_done <= 1'b0;
    end else begin
      remap_done <= remap_i;
      if (remap_i) begin
        map_valid <= nxt_ok;
        map_base  <= nxt_base;
        map_size  <= nxt_size;
      end
    end
  end
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker
  import bwd_pkg::*;
#(
  parameter int NUM_REG = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       remap_i,
  input logic                       io_space_en,
  input logic                       mem_space_en,
  input logic [NUM_REG-1:0][1:0]    reg_kind,
  input logic [NUM_REG-1:0]         map_valid,
  input logic [NUM_REG-1:0][AW-1:0] map_base,
  input logic [NUM_REG-1:0][AW-1:0] map_size,
  input logic                       remap_done
);
  a_r1_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    remap_i |=> remap_done);

  a_r1_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_i |=> !remap_done);

  for (genvar g = 0; g < NUM_REG; g++) begin : g_chk
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !remap_i |=> ($stable(map_valid[g]) && $stable(map_base[g]) && $stable(map_size[g])));

    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !map_valid[g] |-> (map_base[g] == '0 && map_size[g] == '0));

    a_r10_mapped_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      map_valid[g] |-> (map_base[g] != '0 && map_size[g] != '0));

    a_r3_io_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (remap_i && !io_space_en && reg_kind[g] == KIND_IO) |=> !map_valid[g]);

    a_r4_mem_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (remap_i && !mem_space_en && reg_kind[g] != KIND_IO) |=> !map_valid[g]);
  end
endmodule

bind bridge_bar_decoder bwd_checker #(.NUM_REG(NUM_REG)) u_bwd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .remap_i      (remap_i),
  .io_space_en  (io_space_en),
  .mem_space_en (mem_space_en),
  .reg_kind     (reg_kind),
  .map_valid    (map_valid),
  .map_base     (map_base),
  .map_size     (map_size),
  .remap_done   (remap_done)
);

// File: tb/bridge_bar_decoder_bench.sv
module bridge_bar_decoder_bench;
  localparam int NR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic remap_i = 1'b0;
  logic io_space_en = 1'b0, mem_space_en = 1'b0, bridge_present = 1'b0;
  logic [7:0]  win_io_base_lo = 8'h11, win_io_limit_lo = 8'h21;
  logic [15:0] win_io_base_hi = 16'h0, win_io_limit_hi = 16'h0;
  logic [15:0] win_mem_base = 16'hE000, win_mem_limit = 16'hE0F0;
  logic [15:0] win_pf_base_lo = 16'h0010, win_pf_limit_lo = 16'h0020;
  logic [31:0] win_pf_base_hi = 32'h1, win_pf_limit_hi = 32'h1;
  logic [NR-1:0][1:0]  reg_kind = '0;
  logic [NR-1:0]       reg_prefetch = '0;
  logic [NR-1:0][5:0]  reg_size_log2 = '0;
  logic [NR-1:0][63:0] reg_bar = '0;
  logic [NR-1:0]       map_valid;
  logic [NR-1:0][63:0] map_base, map_size;
  logic                remap_done;

  always #10 clk = ~clk;

  bridge_bar_decoder #(.NUM_REG(NR)) u_bridge_bar_decoder (.*);

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) remap_i = 1'b1;
    @(negedge clk) remap_i = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic        pf;
    logic [5:0]  lg;
    logic [63:0] bar;
    logic        io_en;
    logic        mem_en;
    logic        bp;
    logic        ev;
    logic [63:0] eb;
    logic [63:0] es;
  } vec_t;

  // Window setting for the table: I/O 0x1000..0x2FFF, mem 0xE000_0000..0xE0FF_FFFF,
  // prefetch 0x1_0010_0000..0x1_002F_FFFF
  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,6'd4, 64'h1801,             1'b1,1'b0,1'b0,1'b1,64'h1800,        64'h10},       // R3 R6 R11
    '{2'd0,1'b0,6'd8, 64'h1F81,             1'b1,1'b0,1'b1,1'b1,64'h1F00,        64'h100},      // R10 inside
    '{2'd0,1'b0,6'd13,64'h2001,             1'b1,1'b0,1'b1,1'b1,64'h2000,        64'h1000},     // R7 R10 clip at limit
    '{2'd0,1'b0,6'd4, 64'h1801,             1'b0,1'b1,1'b0,1'b0,64'h0,           64'h0},        // R3 io disabled
    '{2'd0,1'b0,6'd4, 64'h0001,             1'b1,1'b0,1'b0,1'b0,64'h0,           64'h0},        // R3 zero address
    '{2'd0,1'b0,6'd4, 64'hFFF1,             1'b1,1'b0,1'b0,1'b1,64'hFFF0,        64'h10},       // R3 end 0xFFFF
    '{2'd0,1'b0,6'd4, 64'h1_0001,           1'b1,1'b0,1'b0,1'b0,64'h0,           64'h0},        // R3 beyond 64K
    '{2'd0,1'b0,6'd4, 64'h3001,             1'b1,1'b0,1'b1,1'b0,64'h0,           64'h0},        // R10 outside
    '{2'd1,1'b0,6'd20,64'hE008_0008,        1'b0,1'b1,1'b1,1'b1,64'hE000_0000,   64'h10_0000},  // R6 R8
    '{2'd1,1'b0,6'd24,64'hE000_0000,        1'b0,1'b1,1'b1,1'b1,64'hE000_0000,   64'h100_0000}, // R8 limit
    '{2'd1,1'b0,6'd28,64'hE000_0000,        1'b0,1'b1,1'b1,1'b1,64'hE000_0000,   64'h100_0000}, // R10 clip
    '{2'd1,1'b0,6'd30,64'hC000_0000,        1'b0,1'b1,1'b0,1'b0,64'h0,           64'h0},        // R4 end FFFFFFFF
    '{2'd1,1'b0,6'd20,64'hE000_0000,        1'b1,1'b0,1'b0,1'b0,64'h0,           64'h0},        // R4 mem disabled
    '{2'd1,1'b0,6'd12,64'hFFFF_F000,        1'b0,1'b1,1'b0,1'b0,64'h0,           64'h0},        // R4 32-bit cap
    '{2'd1,1'b0,6'd12,64'hFFFF_E000,        1'b0,1'b1,1'b0,1'b1,64'hFFFF_E000,   64'h1000},     // R4 below cap
    '{2'd2,1'b0,6'd12,64'h1_FFFF_F00C,      1'b0,1'b1,1'b0,1'b1,64'h1_FFFF_F000, 64'h1000},     // R4 64-bit
    '{2'd2,1'b0,6'd12,64'hFFFF_FFFF_FFFF_F000,1'b0,1'b1,1'b0,1'b0,64'h0,         64'h0},        // R4 all-ones end
    '{2'd2,1'b1,6'd20,64'h1_0010_000C,      1'b0,1'b1,1'b1,1'b1,64'h1_0010_0000, 64'h10_0000},  // R9
    '{2'd2,1'b1,6'd24,64'h1_0000_000C,      1'b0,1'b1,1'b1,1'b1,64'h1_0010_0000, 64'h20_0000},  // R9 R10 both ends
    '{2'd1,1'b1,6'd20,64'hE000_0000,        1'b0,1'b1,1'b1,1'b0,64'h0,           64'h0},        // R9 pf window chosen
    '{2'd3,1'b0,6'd16,64'hE001_0001,        1'b0,1'b1,1'b1,1'b1,64'hE001_0000,   64'h1_0000},   // R5 enabled
    '{2'd3,1'b0,6'd16,64'hE001_0000,        1'b0,1'b1,1'b1,1'b0,64'h0,           64'h0},        // R5 disabled
    '{2'd1,1'b0,6'd0, 64'hE000_0000,        1'b0,1'b1,1'b0,1'b0,64'h0,           64'h0},        // R12 absent
    '{2'd1,1'b0,6'd12,64'h5_0000_3000,      1'b0,1'b1,1'b0,1'b1,64'h3000,        64'h1000}      // R4 upper bits dropped
  };

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset valid", 64'(map_valid), 64'h0);
    chk("R2 reset base0", map_base[0], 64'h0);
    chk("R2 reset done", 64'(remap_done), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 idle valid", 64'(map_valid), 64'h0);
    chk("R2 idle size0", map_size[0], 64'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_kind[0]      = VECS[i].kind;
      reg_prefetch[0]  = VECS[i].pf;
      reg_size_log2[0] = VECS[i].lg;
      reg_bar[0]       = VECS[i].bar;
      io_space_en      = VECS[i].io_en;
      mem_space_en     = VECS[i].mem_en;
      bridge_present   = VECS[i].bp;
      strobe();
      chk($sformatf("vec%0d valid", i), 64'(map_valid[0]), 64'(VECS[i].ev));
      chk($sformatf("vec%0d base", i), map_base[0], VECS[i].eb);
      chk($sformatf("vec%0d size", i), map_size[0], VECS[i].es);
      chk($sformatf("vec%0d R12 absent regions", i), 64'(map_valid[2:1]), 64'h0);
      chk($sformatf("vec%0d R1 done", i), 64'(remap_done), 64'h1);
    end

    // R1: no strobe, inputs move, outputs hold
    @(negedge clk);
    reg_kind[0] = 2'd1; reg_size_log2[0] = 6'd12; reg_bar[0] = 64'h4000;
    mem_space_en = 1'b1; bridge_present = 1'b0;
    strobe();
    chk("R1 loaded base", map_base[0], 64'h4000);
    reg_bar[0] = 64'h8000;
    repeat (3) @(negedge clk);
    chk("R1 hold base", map_base[0], 64'h4000);
    chk("R1 done low", 64'(remap_done), 64'h0);
    strobe();
    chk("R1 reload base", map_base[0], 64'h8000);

    // R7: upper half used only when bit 0 of the low byte is set
    reg_kind[0] = 2'd0; reg_size_log2[0] = 6'd4; reg_bar[0] = 64'h1801;
    io_space_en = 1'b1; bridge_present = 1'b1;
    win_io_base_hi = 16'h0001;
    strobe();
    chk("R7 upper base rejects", 64'(map_valid[0]), 64'h0);
    @(negedge clk);
    win_io_base_lo = 8'h10; win_io_limit_lo = 8'h20;
    strobe();
    chk("R7 16-bit io valid", 64'(map_valid[0]), 64'h1);
    chk("R7 16-bit io base", map_base[0], 64'h1800);

    // R11: windows ignored without a bridge
    win_mem_base = 16'h0010; win_mem_limit = 16'h0010;
    reg_kind[0] = 2'd1; reg_size_log2[0] = 6'd20; reg_bar[0] = 64'hE000_0000;
    bridge_present = 1'b0;
    strobe();
    chk("R11 no bridge size", map_size[0], 64'h10_0000);

    // all regions at once
    @(negedge clk);
    win_mem_base = 16'hE000; win_mem_limit = 16'hE0F0;
    bridge_present = 1'b1;
    reg_kind = {2'd3, 2'd1, 2'd0};
    reg_size_log2 = {6'd16, 6'd20, 6'd4};
    reg_bar = {64'hE002_0001, 64'hE010_0000, 64'h2F01};
    strobe();
    chk("R10 multi io base", map_base[0], 64'h2F00);
    chk("R10 multi mem base", map_base[1], 64'hE010_0000);
    chk("R5 multi rom base", map_base[2], 64'hE002_0000);
    chk("R10 multi valid", 64'(map_valid), 64'h7);

    // R2: reset clears a loaded snapshot
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R2 reset clears valid", 64'(map_valid), 64'h0);
    chk("R2 reset clears base", map_base[1], 64'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule